// File: doc/BRIEF.md
# SMM Protected Memory Range Filter

This block classifies processor memory requests against two regions reserved for system-management mode (SMM). The first is a fixed 128 kB legacy window starting at A0000h. The second is a segment placed just below a programmable top-of-segment boundary. The top is set in 256 MB steps, and the segment size is chosen from four powers of two between 512 kB and 4 MB. Each request carries a 40-bit address and a flag that marks it as made in SMM mode. One cycle later the block returns a route:
- DRAM, for SMM-mode hits in an enabled region.
- The downstream I/O port, for non-SMM hits.
- None, when the address is outside both regions.

Firmware programs the block through a two-entry configuration register file with a simple write port and a combinational read port. The file holds a global enable, a segment enable, the size code, the top field and a sticky lock bit. Once the lock bit is set, the configuration is frozen until reset. This stops later code from moving or disabling the protected ranges.

Top module: `smm_range_filter`

## Requirements
- R1: After reset, register 0 reads 00h, register 1 reads 01h (top = 256 MB), and `rsp_valid` is 0.
- R2: Register 0 bits 3:2 hold the size code. 00 selects 512 kB, 01 selects 1 MB, 10 selects 2 MB and 11 selects 4 MB. The segment runs from top minus the size up to top.
- R3: A segment hit requires base <= address < top: the base address is included and the top address is excluded.
- R4: A request whose address bits 39:32 are not all zero never hits either region and returns route 00 (none).
- R5: The segment is active only when register 0 bit 0 (global enable) and bit 1 (segment enable) are both 1. Otherwise, addresses in the segment return route 00.
- R6: A hit in an active region returns route 01 (DRAM) when `req_smm` is 1, and route 10 (I/O port) when `req_smm` is 0. Route 11 never appears.
- R7: When the global enable is 1, addresses A0000h to BFFFFh form the legacy window and follow the routing of R6. C0000h and 9FFFFh are outside it.
- R8: Register 0 bit 7 is the lock. It can only be set by a write and is cleared only by reset. While it is 1, writes to either register leave every field unchanged.
- R9: A write that sets the lock also updates the other fields of register 0 in that same cycle.
- R10: Reserved bits read back as 0 and ignore writes. These are register 0 bits 6:4 and register 1 bits 7:4.
- R11: `rsp_valid` and `rsp_route` appear exactly one cycle after `req_valid`. When `req_valid` is 0, `rsp_valid` is 0 on the next cycle and `rsp_route` is 00.
- R12: Register 1 bits 3:0 hold address bits 31:28 of the top. If top minus size would fall below zero (top field 0), the segment is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select for both read and write (0 = control, 1 = top) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data of the selected register |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Request physical address |
| req_smm | input | 1 | Request is made in SMM mode |
| rsp_valid | output | 1 | Route result valid, one cycle after the request |
| rsp_route | output | 2 | 00 none, 01 DRAM, 10 I/O port |

## Verification
Two cases are hard to reach from the ports: the lock taking hold in the same write that also changes the other fields, and a locked block that must keep its old segment even though firmware tries to move it. The bench programs a non-default top before locking. The locking write also changes the enables, and the bench confirms that this change took effect. It then attempts to rewrite both registers and probes the old segment's edges through the request port, as well as reading the registers back. The segment wrap case (top field 0) is reached by writing the top to zero and probing addresses near 4 GB and near zero.

// File: rtl/smm_filter_pkg.sv
package smm_filter_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_DRAM = 2'b01,
    ROUTE_IO   = 2'b10
  } route_e;

  // control register field positions
  localparam int CTL_GEN  = 0;
  localparam int CTL_SEN  = 1;
  localparam int CTL_SZLO = 2;
  localparam int CTL_LOCK = 7;

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int TOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              glob_en,
  output logic              seg_en,
  output logic [1:0]        size_code,
  output logic [TOP_W-1:0]  top_field
);
  import smm_filter_pkg::*;

  logic             lock_q, lock_d;
  logic             gen_q, gen_d, sen_q, sen_d;
  logic [1:0]       sz_q, sz_d;
  logic [TOP_W-1:0] top_q, top_d;
  logic             ctl_wr, top_wr;

  assign ctl_wr = we && !sel && !lock_q;
  assign top_wr = we &&  sel && !lock_q;

  always_comb begin
    lock_d = lock_q;
    gen_d  = gen_q;
    sen_d  = sen_q;
    sz_d   = sz_q;
    top_d  = top_q;
    if (ctl_wr) begin
      lock_d = wdata[CTL_LOCK];
      gen_d  = wdata[CTL_GEN];
      sen_d  = wdata[CTL_SEN];
      sz_d   = wdata[CTL_SZLO +: 2];
    end
    if (top_wr) top_d = wdata[TOP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      gen_q  <= 1'b0;
      sen_q  <= 1'b0;
      sz_q   <= 2'b00;
      top_q  <= TOP_W'(1);
    end else begin
      lock_q <= lock_d;
      gen_q  <= gen_d;
      sen_q  <= sen_d;
      sz_q   <= sz_d;
      top_q  <= top_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[TOP_W-1:0] = top_q;
    end else begin
      rdata[CTL_GEN]       = gen_q;
      rdata[CTL_SEN]       = sen_q;
      rdata[CTL_SZLO +: 2] = sz_q;
      rdata[CTL_LOCK]      = lock_q;
    end
  end

  assign glob_en   = gen_q;
  assign seg_en    = sen_q;
  assign size_code = sz_q;
  assign top_field = top_q;

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // R8: lock never clears once set
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8: locked fields keep their value whatever is written
  assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(gen_q) && $stable(sen_q) && $stable(sz_q) && $stable(top_q)));
  // R10: reserved read bits are zero
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (rdata[DATA_W-1:TOP_W] == '0));

endmodule

// File: rtl/smm_range_decode.sv
module smm_range_decode #(
  parameter int          ADDR_W   = 40,
  parameter int          LOW_W    = 32,
  parameter int          TOP_W    = 4,
  parameter int          SZ_LOG2  = 19,
  parameter int          LEG_LOG2 = 17,
  parameter logic [31:0] LEG_BASE = 32'h000A_0000
) (
  input  logic              glob_en,
  input  logic              seg_en,
  input  logic [1:0]        size_code,
  input  logic [TOP_W-1:0]  top_field,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  output smm_filter_pkg::route_e route
);
  import smm_filter_pkg::*;

  localparam int EXT_W   = LOW_W + 1;
  localparam int TOP_LSB = LOW_W - TOP_W;

  logic             below_4g;
  logic [EXT_W-1:0] top_x, size_x, base_x, addr_x;
  logic             seg_nonempty, seg_hit, leg_hit;

  always_comb begin
    below_4g     = (addr[ADDR_W-1:LOW_W] == '0);
    addr_x       = {1'b0, addr[LOW_W-1:0]};
    top_x        = {1'b0, top_field, {TOP_LSB{1'b0}}};
    size_x       = EXT_W'(1) << (SZ_LOG2 + int'(size_code));
    base_x       = top_x - size_x;
    seg_nonempty = (top_x >= size_x);
    seg_hit      = glob_en && seg_en && seg_nonempty && below_4g &&
                   (addr_x >= base_x) && (addr_x < top_x);
    leg_hit      = glob_en && below_4g &&
                   (addr[LOW_W-1:LEG_LOG2] == LEG_BASE[LOW_W-1:LEG_LOG2]);
    if (seg_hit || leg_hit) route = smm ? ROUTE_DRAM : ROUTE_IO;
    else                    route = ROUTE_NONE;
  end

endmodule

// File: rtl/smm_range_filter.sv
module smm_range_filter #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 8,
  parameter int TOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  output logic              rsp_valid,
  output logic [1:0]        rsp_route
);
  import smm_filter_pkg::*;

  localparam int LOW_W = 32;

  logic       rst_meta, rst_sync_n;
  logic       glob_en, seg_en;
  logic [1:0] size_code;
  logic [TOP_W-1:0] top_field;
  route_e     route_c;
  logic       vld_d;
  logic [1:0] route_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  smm_cfg_regs #(.DATA_W(DATA_W), .TOP_W(TOP_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .glob_en(glob_en),
    .seg_en(seg_en), .size_code(size_code), .top_field(top_field)
  );

  smm_range_decode #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .TOP_W(TOP_W)) u_dec (
    .glob_en(glob_en), .seg_en(seg_en), .size_code(size_code),
    .top_field(top_field), .addr(req_addr), .smm(req_smm), .route(route_c)
  );

  always_comb begin
    vld_d   = req_valid;
    route_d = req_valid ? route_c : ROUTE_NONE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= ROUTE_NONE;
    end else begin
      rsp_valid <= vld_d;
      rsp_route <= route_d;
    end
  end

  // R11: one-cycle latency on the valid strobe
  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  assert_idle_none_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && rsp_route == ROUTE_NONE));
  // R4: above 4 GB never hits
  assert_high_addr_none_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr[ADDR_W-1:LOW_W] != '0) |=> rsp_route == ROUTE_NONE);
  // R5: nothing hits without the global enable
  assert_disabled_none_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !glob_en) |=> rsp_route == ROUTE_NONE);
  // R6: no illegal route code
  assert_route_legal_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_route != 2'b11);

endmodule

// File: tb/smm_range_filter_test.sv
module smm_range_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        req_valid;
  logic [39:0] req_addr;
  logic        req_smm;
  logic        rsp_valid;
  logic [1:0]  rsp_route;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [1:0] NONE = 2'b00, DRAM = 2'b01, IO = 2'b10;

  always #4 clk = ~clk;

  smm_range_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_smm(req_smm), .rsp_valid(rsp_valid),
    .rsp_route(rsp_route)
  );

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic sel, logic [7:0] exp);
    @(negedge clk);
    cfg_addr = sel;
    #1;
    check(req, 40'(cfg_rdata), 40'(exp));
  endtask

  task automatic probe(string req, logic [39:0] a, logic smm, logic [1:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_smm = smm;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 40'(rsp_valid), 40'd1);
    check(req, 40'(rsp_route), 40'(exp));
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", 40'(rsp_valid), 40'd0);
    rd_check("R1 ctrl", 1'b0, 8'h00);
    rd_check("R1 top", 1'b1, 8'h01);
  endtask

  task automatic t_enables;
    probe("R5 no enables", 40'h0FF8_0000, 1'b1, NONE);
    wr(1'b0, 8'h01);
    probe("R5 global only", 40'h0FF8_0000, 1'b1, NONE);
    wr(1'b0, 8'h02);
    probe("R5 segment only", 40'h0FFF_FFFF, 1'b1, NONE);
    wr(1'b0, 8'h03);
    probe("R5 both", 40'h0FF8_0000, 1'b1, DRAM);
  endtask

  task automatic t_sizes;
    wr(1'b1, 8'h02);
    for (int c = 0; c < 4; c++) begin
      logic [39:0] top, base;
      top  = 40'h2000_0000;
      base = top - (40'd1 << (19 + c));
      wr(1'b0, 8'(8'h03 | (c << 2)));
      probe("R2 base", base, 1'b1, DRAM);
      probe("R3 below base", base - 1, 1'b1, NONE);
      probe("R3 top-1", top - 1, 1'b1, DRAM);
      probe("R3 top excluded", top, 1'b1, NONE);
    end
  endtask

  task automatic t_routing;
    wr(1'b0, 8'h03);
    probe("R6 smm hit", 40'h1FFC_0000, 1'b1, DRAM);
    probe("R6 non-smm hit", 40'h1FFC_0000, 1'b0, IO);
    probe("R6 miss", 40'h0000_1000, 1'b0, NONE);
    probe("R4 high bits", 40'h01_1FFC_0000, 1'b1, NONE);
    probe("R4 high legacy", 40'h80_000A_0000, 1'b1, NONE);
  endtask

  task automatic t_legacy;
    probe("R7 low edge", 40'h000A_0000, 1'b1, DRAM);
    probe("R7 high edge io", 40'h000B_FFFF, 1'b0, IO);
    probe("R7 above", 40'h000C_0000, 1'b1, NONE);
    probe("R7 below", 40'h0009_FFFF, 1'b1, NONE);
  endtask

  task automatic t_wrap;
    wr(1'b1, 8'h00);
    probe("R12 empty near 4G", 40'hFFF8_0000, 1'b1, NONE);
    probe("R12 empty at 0", 40'h0000_0000, 1'b1, NONE);
    wr(1'b1, 8'h02);
  endtask

  task automatic t_reserved;
    wr(1'b1, 8'hF3);
    rd_check("R10 top reserved", 1'b1, 8'h03);
    wr(1'b0, 8'h70);
    rd_check("R10 ctrl reserved", 1'b0, 8'h00);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 40'h000A_0000; req_smm = 1'b1;
    @(negedge clk);
    check("R11 idle valid", 40'(rsp_valid), 40'd0);
    check("R11 idle route", 40'(rsp_route), 40'(NONE));
  endtask

  task automatic t_lock;
    // top is 3 (768 MB) from t_reserved; lock write also enables, size 00
    wr(1'b0, 8'h83);
    rd_check("R9 lock write fields", 1'b0, 8'h83);
    probe("R9 segment live", 40'h2FF8_0000, 1'b1, DRAM);
    wr(1'b0, 8'h0C);
    wr(1'b1, 8'h05);
    rd_check("R8 ctrl frozen", 1'b0, 8'h83);
    rd_check("R8 top frozen", 1'b1, 8'h03);
    probe("R8 old base", 40'h2FF8_0000, 1'b1, DRAM);
    probe("R8 old base-1", 40'h2FF7_FFFF, 1'b1, NONE);
    probe("R8 new top ignored", 40'h4FFF_FFFF, 1'b1, NONE);
  endtask

  initial begin
    #1_600_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_smm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_enables;
    t_sizes;
    t_routing;
    t_legacy;
    t_wrap;
    t_reserved;
    t_latency;
    t_lock;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule